// File: doc/BRIEF.md
# Flash Address Window Permission Checker

This block holds a bank of programmable address windows over a flash array and decides, for each query, whether a given bus master may perform a read or a write/erase at a given address. Every window carries an inclusive start page and limit page (4 KB pages, taken from address bits [31:12]), a read grant bitmap and a write/erase grant bitmap, each with one bit per master ID. A configuration port programs the window fields one at a time, and a separate lock input makes a window permanently read-only until the next reset.

A query is a single-cycle strobe carrying address, master ID and access kind. The answer appears, registered, on the following cycle: allow or deny, whether any window matched, and the index of the lowest-numbered matching window. Access is granted when at least one matching window grants the requesting master the requested kind, so overlapping windows add their grants together.

The response path is a two-state machine. State `Q_IDLE` (no response on the outputs) moves to `Q_RESP` on a query strobe (transition *accept*); `Q_RESP` stays in `Q_RESP` when another strobe arrives (transition *chain*) and returns to `Q_IDLE` when none does (transition *drain*). `Q_IDLE` stays put with no strobe (transition *wait*).

Top module: `flash_region_guard`

## Requirements
- R1: After reset every window has start page 0x7FFFF, limit page 0, write/erase bitmap 0x01 and read bitmap 0x01, and no window is locked; a query then returns deny with no hit and region index 0.
- R2: A configuration write with `cfg_we` high updates one field of window `cfg_region`, selected by `cfg_field` (0 = start page, 1 = limit page, 2 = write/erase bitmap from `cfg_wdata[7:0]`, 3 = read bitmap from `cfg_wdata[7:0]`); a write naming a window index of 17 or more changes nothing.
- R3: An address matches a window when start page <= address[31:12] <= limit page, both bounds inclusive; address bits [11:0] do not affect matching.
- R4: A read query (`q_write` = 0) consults bit `q_master` of the read bitmap; a write/erase query (`q_write` = 1) consults bit `q_master` of the write/erase bitmap.
- R5: A query is allowed when any matching window grants the master the requested kind, even if a lower-numbered matching window does not; otherwise it is denied.
- R6: `r_hit` is high when any window matches, and `r_region` then holds the lowest matching window index (0 when nothing matches).
- R7: `lock_set` with `lock_region` locks that window; afterwards configuration writes to it have no effect, other windows stay programmable, and the lock clears only on reset.
- R8: `r_valid` is high exactly in the cycle after a cycle with `q_valid` high, so back-to-back strobes give back-to-back responses, and exactly one of `r_allow`/`r_deny` is high with it.
- R9: A query issued in the same cycle as a configuration write is answered with the window contents from before that write.
- R10: A window whose start page exceeds its limit page matches no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration field write strobe |
| cfg_region | input | 5 | Window index for the write |
| cfg_field | input | 2 | Field select: 0 start, 1 limit, 2 write/erase bitmap, 3 read bitmap |
| cfg_wdata | input | 20 | Field value (bitmaps use the low 8 bits) |
| lock_set | input | 1 | Lock strobe |
| lock_region | input | 5 | Window index to lock |
| q_valid | input | 1 | Query strobe |
| q_addr | input | 32 | Flash byte address of the query |
| q_master | input | 3 | Requesting master ID |
| q_write | input | 1 | 1 = write/erase, 0 = read |
| r_valid | output | 1 | Response valid |
| r_allow | output | 1 | Access granted |
| r_deny | output | 1 | Access refused |
| r_hit | output | 1 | At least one window matched |
| r_region | output | 5 | Lowest matching window index |

## Verification
The hardest thing to see from the ports is that a locked window really ignored a write, because the window registers are never read back; the stimulus programs a window, locks it, attempts to widen its read grant and to shrink its limit, and then probes addresses and masters whose answers would flip had either write landed. A second awkward case is the write that lands in the same cycle as a query, reached by raising `cfg_we` and `q_valid` on the same edge and following up with a second query that must see the new value.

// File: rtl/frg_pkg.sv
package frg_pkg;

    typedef enum logic [1:0] {
        FLD_START = 2'd0,
        FLD_LIMIT = 2'd1,
        FLD_WMASK = 2'd2,
        FLD_RMASK = 2'd3
    } frg_field_e;

    typedef enum logic {
        Q_IDLE = 1'b0,
        Q_RESP = 1'b1
    } frg_qstate_e;

endpackage

// File: rtl/frg_region_bank.sv
module frg_region_bank #(
    parameter int NUM_REGIONS = 17,
    parameter int NUM_MASTERS = 8,
    parameter int BOUND_W     = 20,
    parameter int IDX_W       = 5,
    parameter int DATA_W      = 20
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       cfg_we,
    input  logic [IDX_W-1:0]                           cfg_region,
    input  logic [1:0]                                 cfg_field,
    input  logic [DATA_W-1:0]                          cfg_wdata,
    input  logic                                       lock_set,
    input  logic [IDX_W-1:0]                           lock_region,
    output logic [NUM_REGIONS-1:0][BOUND_W-1:0]        start_pg,
    output logic [NUM_REGIONS-1:0][BOUND_W-1:0]        limit_pg,
    output logic [NUM_REGIONS-1:0][NUM_MASTERS-1:0]    wmask,
    output logic [NUM_REGIONS-1:0][NUM_MASTERS-1:0]    rmask
);
    import frg_pkg::*;

    localparam logic [BOUND_W-1:0]     EMPTY_START = {1'b0, {(BOUND_W-1){1'b1}}};
    localparam logic [BOUND_W-1:0]     EMPTY_LIMIT = '0;
    localparam logic [NUM_MASTERS-1:0] DFLT_GRANT  = NUM_MASTERS'(1);

    logic [NUM_REGIONS-1:0] locked;
    frg_field_e             fsel;

    assign fsel = frg_field_e'(cfg_field);

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_win
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
        logic wr_ok;

        assign wr_ok = cfg_we && (cfg_region == MY_IDX) && !locked[i];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                start_pg[i] <= EMPTY_START;
                limit_pg[i] <= EMPTY_LIMIT;
                wmask[i]    <= DFLT_GRANT;
                rmask[i]    <= DFLT_GRANT;
            end else if (wr_ok) begin
                unique case (fsel)
                    FLD_START: start_pg[i] <= cfg_wdata[BOUND_W-1:0];
                    FLD_LIMIT: limit_pg[i] <= cfg_wdata[BOUND_W-1:0];
                    FLD_WMASK: wmask[i]    <= cfg_wdata[NUM_MASTERS-1:0];
                    FLD_RMASK: rmask[i]    <= cfg_wdata[NUM_MASTERS-1:0];
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                locked[i] <= 1'b0;
            end else if (lock_set && (lock_region == MY_IDX)) begin
                locked[i] <= 1'b1;
            end
        end

        // R7: a lock, once set, stays set until reset
        assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $past(locked[i]) |-> locked[i]);

        // R7: a locked window keeps every field unchanged
        assert_locked_fields_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $past(locked[i]) |-> ($stable(start_pg[i]) && $stable(limit_pg[i])
                                  && $stable(wmask[i]) && $stable(rmask[i])));
    end

endmodule

// File: rtl/frg_match.sv
module frg_match #(
    parameter int NUM_REGIONS = 17,
    parameter int NUM_MASTERS = 8,
    parameter int BOUND_W     = 20,
    parameter int IDX_W       = 5,
    parameter int MID_W       = 3
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [BOUND_W-1:0]                      q_page,
    input  logic [MID_W-1:0]                        q_master,
    input  logic                                    q_write,
    input  logic [NUM_REGIONS-1:0][BOUND_W-1:0]     start_pg,
    input  logic [NUM_REGIONS-1:0][BOUND_W-1:0]     limit_pg,
    input  logic [NUM_REGIONS-1:0][NUM_MASTERS-1:0] wmask,
    input  logic [NUM_REGIONS-1:0][NUM_MASTERS-1:0] rmask,
    output logic                                    any_hit,
    output logic                                    any_grant,
    output logic [IDX_W-1:0]                        first_idx
);
    logic [NUM_REGIONS-1:0] hit;
    logic [NUM_REGIONS-1:0] grant;

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_cmp
        logic perm;
        assign hit[i]   = (q_page >= start_pg[i]) && (q_page <= limit_pg[i]);
        assign perm     = q_write ? wmask[i][q_master] : rmask[i][q_master];
        assign grant[i] = hit[i] && perm;
    end

    assign any_hit   = |hit;
    assign any_grant = |grant;

    always_comb begin
        first_idx = '0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (hit[i]) first_idx = IDX_W'(i);
        end
    end

    // R6: the reported index names a window that actually matched
    assert_first_is_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> hit[first_idx]);

    // R6: no window below the reported index matched
    assert_first_is_lowest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> ((hit & ((NUM_REGIONS'(1) << first_idx) - NUM_REGIONS'(1))) == '0));

    // R5: a grant is only possible through a matching window
    assert_grant_needs_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        any_grant |-> any_hit);

endmodule

// File: rtl/frg_query_fsm.sv
module frg_query_fsm #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             q_valid,
    input  logic             m_hit,
    input  logic             m_grant,
    input  logic [IDX_W-1:0] m_idx,
    output logic             r_valid,
    output logic             r_allow,
    output logic             r_deny,
    output logic             r_hit,
    output logic [IDX_W-1:0] r_region
);
    import frg_pkg::*;

    frg_qstate_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_IDLE: if (q_valid)  state_d = Q_RESP;   // accept
            Q_RESP: if (!q_valid) state_d = Q_IDLE;   // drain (else chain)
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= Q_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_allow  <= 1'b0;
            r_deny   <= 1'b0;
            r_hit    <= 1'b0;
            r_region <= '0;
        end else if (q_valid) begin
            r_allow  <= m_grant;
            r_deny   <= !m_grant;
            r_hit    <= m_hit;
            r_region <= m_hit ? m_idx : '0;
        end else begin
            r_allow  <= 1'b0;
            r_deny   <= 1'b0;
            r_hit    <= 1'b0;
            r_region <= '0;
        end
    end

    assign r_valid = (state_q == Q_RESP);

    // R8: every strobe gets a response on the next cycle
    assert_resp_after_query_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |=> r_valid);

    // R8: no response without a strobe in the previous cycle
    assert_no_spurious_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |=> !r_valid);

    // R8: a response carries exactly one verdict
    assert_one_verdict_R8: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid |-> $onehot({r_allow, r_deny}));

    // R5: an allow is only ever reported with a hit
    assert_allow_has_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        r_allow |-> r_hit);

endmodule

// File: rtl/flash_region_guard.sv
module flash_region_guard #(
    parameter int NUM_REGIONS = 17,
    parameter int NUM_MASTERS = 8,
    parameter int ADDR_W      = 32,
    parameter int PAGE_LSB    = 12,
    localparam int BOUND_W    = ADDR_W - PAGE_LSB,
    localparam int IDX_W      = $clog2(NUM_REGIONS),
    localparam int MID_W      = $clog2(NUM_MASTERS),
    localparam int DATA_W     = (BOUND_W > NUM_MASTERS) ? BOUND_W : NUM_MASTERS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_region,
    input  logic [1:0]        cfg_field,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              lock_set,
    input  logic [IDX_W-1:0]  lock_region,
    input  logic              q_valid,
    input  logic [ADDR_W-1:0] q_addr,
    input  logic [MID_W-1:0]  q_master,
    input  logic              q_write,
    output logic              r_valid,
    output logic              r_allow,
    output logic              r_deny,
    output logic              r_hit,
    output logic [IDX_W-1:0]  r_region
);
    logic [NUM_REGIONS-1:0][BOUND_W-1:0]     start_pg;
    logic [NUM_REGIONS-1:0][BOUND_W-1:0]     limit_pg;
    logic [NUM_REGIONS-1:0][NUM_MASTERS-1:0] wmask;
    logic [NUM_REGIONS-1:0][NUM_MASTERS-1:0] rmask;
    logic                                    m_hit;
    logic                                    m_grant;
    logic [IDX_W-1:0]                        m_idx;

    frg_region_bank #(
        .NUM_REGIONS(NUM_REGIONS), .NUM_MASTERS(NUM_MASTERS),
        .BOUND_W(BOUND_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_region(cfg_region), .cfg_field(cfg_field),
        .cfg_wdata(cfg_wdata), .lock_set(lock_set), .lock_region(lock_region),
        .start_pg(start_pg), .limit_pg(limit_pg), .wmask(wmask), .rmask(rmask)
    );

    frg_match #(
        .NUM_REGIONS(NUM_REGIONS), .NUM_MASTERS(NUM_MASTERS),
        .BOUND_W(BOUND_W), .IDX_W(IDX_W), .MID_W(MID_W)
    ) u_match (
        .clk(clk), .rst_n(rst_n),
        .q_page(q_addr[ADDR_W-1:PAGE_LSB]), .q_master(q_master), .q_write(q_write),
        .start_pg(start_pg), .limit_pg(limit_pg), .wmask(wmask), .rmask(rmask),
        .any_hit(m_hit), .any_grant(m_grant), .first_idx(m_idx)
    );

    frg_query_fsm #(
        .IDX_W(IDX_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .q_valid(q_valid),
        .m_hit(m_hit), .m_grant(m_grant), .m_idx(m_idx),
        .r_valid(r_valid), .r_allow(r_allow), .r_deny(r_deny),
        .r_hit(r_hit), .r_region(r_region)
    );

endmodule

// File: tb/flash_region_guard_bench.sv
module flash_region_guard_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [4:0]  cfg_region;
    logic [1:0]  cfg_field;
    logic [19:0] cfg_wdata;
    logic        lock_set;
    logic [4:0]  lock_region;
    logic        q_valid;
    logic [31:0] q_addr;
    logic [2:0]  q_master;
    logic        q_write;
    logic        r_valid, r_allow, r_deny, r_hit;
    logic [4:0]  r_region;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_region_guard u_flash_region_guard (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_region(cfg_region), .cfg_field(cfg_field),
        .cfg_wdata(cfg_wdata), .lock_set(lock_set), .lock_region(lock_region),
        .q_valid(q_valid), .q_addr(q_addr), .q_master(q_master), .q_write(q_write),
        .r_valid(r_valid), .r_allow(r_allow), .r_deny(r_deny),
        .r_hit(r_hit), .r_region(r_region)
    );

    task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic expect_resp(string tag, bit allow, bit hit, logic [4:0] idx);
        check(tag, "r_valid", 32'(r_valid), 32'd1);
        check(tag, "r_allow", 32'(r_allow), 32'(allow));
        check(tag, "r_deny", 32'(r_deny), 32'(!allow));
        check(tag, "r_hit", 32'(r_hit), 32'(hit));
        check(tag, "r_region", 32'(r_region), 32'(idx));
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cfg_write(logic [4:0] rg, logic [1:0] fld, logic [19:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_region = rg; cfg_field = fld; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic program_window(logic [4:0] rg, logic [19:0] s, logic [19:0] l,
                                  logic [7:0] wm, logic [7:0] rm);
        cfg_write(rg, 2'd0, s);
        cfg_write(rg, 2'd1, l);
        cfg_write(rg, 2'd2, 20'(wm));
        cfg_write(rg, 2'd3, 20'(rm));
    endtask

    task automatic lock_window(logic [4:0] rg);
        @(negedge clk);
        lock_set = 1'b1; lock_region = rg;
        @(negedge clk);
        lock_set = 1'b0;
    endtask

    task automatic query(logic [31:0] a, logic [2:0] m, bit wr);
        @(negedge clk);
        q_valid = 1'b1; q_addr = a; q_master = m; q_write = wr;
        @(negedge clk);
        q_valid = 1'b0;
    endtask

    // R1, R10: reset contents give empty windows and nothing matches
    task automatic t_reset();
        check("R1", "r_valid idle", 32'(r_valid), 32'd0);
        query(32'h0000_0000, 3'd0, 1'b0);
        expect_resp("R1", 1'b0, 1'b0, 5'd0);
        query(32'h7FFF_F000, 3'd0, 1'b1);
        expect_resp("R10", 1'b0, 1'b0, 5'd0);
    endtask

    // R2, R3, R4: field programming, inclusive bounds, per-kind bitmaps
    task automatic t_basic();
        program_window(5'd3, 20'h00010, 20'h0001F, 8'h02, 8'h05);
        query(32'h0001_0000, 3'd0, 1'b0);
        expect_resp("R2", 1'b1, 1'b1, 5'd3);
        query(32'h0001_FFFF, 3'd2, 1'b0);
        expect_resp("R3", 1'b1, 1'b1, 5'd3);
        query(32'h0002_0000, 3'd0, 1'b0);
        expect_resp("R3", 1'b0, 1'b0, 5'd0);
        query(32'h0000_FFFF, 3'd0, 1'b0);
        expect_resp("R3", 1'b0, 1'b0, 5'd0);
        query(32'h0001_5000, 3'd1, 1'b0);
        expect_resp("R4", 1'b0, 1'b1, 5'd3);
        query(32'h0001_5000, 3'd1, 1'b1);
        expect_resp("R4", 1'b1, 1'b1, 5'd3);
        query(32'h0001_5000, 3'd0, 1'b1);
        expect_resp("R4", 1'b0, 1'b1, 5'd3);
    endtask

    // R2: writes naming a nonexistent window are dropped
    task automatic t_bad_index();
        program_window(5'd20, 20'h00000, 20'h7FFFF, 8'hFF, 8'hFF);
        query(32'h4000_0000, 3'd5, 1'b0);
        expect_resp("R2", 1'b0, 1'b0, 5'd0);
    endtask

    // R5, R6: overlapping windows, lowest index reported, grants combined
    task automatic t_overlap();
        program_window(5'd1, 20'h00010, 20'h00030, 8'h00, 8'h00);
        query(32'h0001_5000, 3'd0, 1'b0);
        expect_resp("R5", 1'b1, 1'b1, 5'd1);
        query(32'h0001_5000, 3'd7, 1'b0);
        expect_resp("R6", 1'b0, 1'b1, 5'd1);
        query(32'h0002_8000, 3'd0, 1'b0);
        expect_resp("R6", 1'b0, 1'b1, 5'd1);
    endtask

    // R7: locked window ignores writes, others stay programmable
    task automatic t_lock();
        lock_window(5'd3);
        cfg_write(5'd3, 2'd3, 20'h000FF);
        query(32'h0001_5000, 3'd7, 1'b0);
        expect_resp("R7", 1'b0, 1'b1, 5'd1);
        cfg_write(5'd3, 2'd1, 20'h0000F);
        query(32'h0001_F000, 3'd0, 1'b0);
        expect_resp("R7", 1'b1, 1'b1, 5'd1);
        program_window(5'd5, 20'h00100, 20'h00100, 8'h00, 8'h80);
        query(32'h0010_0123, 3'd7, 1'b0);
        expect_resp("R7", 1'b1, 1'b1, 5'd5);
    endtask

    // R8: back-to-back strobes and the idle cycle after them
    task automatic t_back_to_back();
        @(negedge clk);
        q_valid = 1'b1; q_addr = 32'h0010_0000; q_master = 3'd7; q_write = 1'b0;
        @(negedge clk);
        expect_resp("R8", 1'b1, 1'b1, 5'd5);
        q_addr = 32'h0000_1000; q_master = 3'd7;
        @(negedge clk);
        q_valid = 1'b0;
        expect_resp("R8", 1'b0, 1'b0, 5'd0);
        @(negedge clk);
        check("R8", "r_valid after drain", 32'(r_valid), 32'd0);
    endtask

    // R9: write and query in the same cycle
    task automatic t_same_cycle();
        program_window(5'd6, 20'h00200, 20'h00200, 8'h01, 8'h01);
        @(negedge clk);
        cfg_we = 1'b1; cfg_region = 5'd6; cfg_field = 2'd3; cfg_wdata = 20'h0;
        q_valid = 1'b1; q_addr = 32'h0020_0000; q_master = 3'd0; q_write = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0; q_valid = 1'b0;
        expect_resp("R9", 1'b1, 1'b1, 5'd6);
        query(32'h0020_0000, 3'd0, 1'b0);
        expect_resp("R9", 1'b0, 1'b1, 5'd6);
    endtask

    // R1, R7: reset restores defaults and releases locks
    task automatic t_reset_unlocks();
        apply_reset();
        query(32'h0001_5000, 3'd0, 1'b0);
        expect_resp("R1", 1'b0, 1'b0, 5'd0);
        program_window(5'd3, 20'h00010, 20'h0001F, 8'h00, 8'hFF);
        query(32'h0001_5000, 3'd7, 1'b0);
        expect_resp("R7", 1'b1, 1'b1, 5'd3);
    endtask

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_region = '0; cfg_field = '0; cfg_wdata = '0;
        lock_set = 1'b0; lock_region = '0;
        q_valid = 1'b0; q_addr = '0; q_master = '0; q_write = 1'b0;
        apply_reset();
        t_reset();
        t_basic();
        t_bad_index();
        t_overlap();
        t_lock();
        t_back_to_back();
        t_same_cycle();
        t_reset_unlocks();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int n = 0; n < WATCHDOG; n++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule